// File: doc/BRIEF.md
# Display-Enable Word Load Sequencer

This block sits between a raster timing generator and a pixel serializer. It watches the display-enable level that the timing generator produces. A fixed number of cycles after enable goes high, it starts issuing one-cycle LOAD strobes, one for each 16-bit memory word handed to the serializer. The strobes repeat at a fixed period for as long as enable stays high. The same fixed latency applies when enable falls, so the strobes also stop that many cycles later.

Each LOAD advances a video address counter by one word (two bytes). A frame-start strobe reloads the counter from a base value, and this reload takes priority over the advance. The serializer needs a fixed time before the first pixel of a run is valid, so the block also raises a one-cycle first-pixel flag that trails the first LOAD of each enable run by that delay. The latencies are fixed and do not depend on any phase relationship at power-up.

Cycle numbering: a value applied to an input during cycle t is sampled at the clock edge that ends cycle t. A registered result of that value is visible during cycle t+1.

Top module: `dl_word_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `load_o` and `first_pix_o` are 0 and `vaddr_o` is 0.
- R2: If `de_i` is high in cycle t and low in cycle t-1 (or t is the first cycle after reset), the first `load_o` pulse of that run is high in cycle t+4. Internally, enable is seen 2 cycles after it rises (cycle t+2).
- R3: While `de_i` stays high, `load_o` repeats every 4 cycles: it is high in cycle t+4+4k for every k with `de_i` high in cycle t+4k. Each pulse is one cycle wide.
- R4: `load_o` is high in cycle c only if `de_i` was high in cycle c-4. If `de_i` goes low in cycle f, no pulse of that run appears from cycle f+4 on.
- R5: If `load_o` is high in cycle c and `frame_start_i` is low in cycle c, then `vaddr_o` in cycle c+1 equals `vaddr_o` in cycle c plus 2, modulo 2^ADDR_W. With neither signal high, `vaddr_o` holds its value.
- R6: If `frame_start_i` is high in cycle c, then `vaddr_o` in cycle c+1 equals `base_i` from cycle c. This applies even when `load_o` is high in cycle c.
- R7: `first_pix_o` is a one-cycle pulse in cycle L+18 for each cycle L that holds the first `load_o` of an enable run, and at no other time. Later pulses of the same run produce no flag.
- R8: An enable run of n consecutive high cycles yields exactly ceil(n/4) LOAD pulses, so a single high cycle still yields one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de_i | input | 1 | Display-enable level from the timing generator |
| frame_start_i | input | 1 | Reload strobe for the video address counter |
| base_i | input | ADDR_W | Value loaded into the address counter on frame start |
| load_o | output | 1 | One-cycle strobe: one word available to the serializer |
| vaddr_o | output | ADDR_W | Video address counter, byte address |
| first_pix_o | output | 1 | One-cycle flag: first pixel of a run is valid |

## Verification
The three results are due at different times after a stimulus:
- `vaddr_o` responds one cycle after a LOAD or frame-start cycle.
- `load_o` responds four cycles after the enable sample that caused it.
- `first_pix_o` responds eighteen cycles after the first LOAD of a run.

The bench first builds the whole input sequence. It then computes an expected value for each output in each cycle, placing it at the cycle that latency gives. It compares the outputs once per cycle at the falling edge, before that cycle's inputs are applied, so every comparison sees settled values for a known cycle. Directed runs of length 1, 4, 5, 8 and 40 cycles are mixed with random enable runs and random reloads. One reload lands on a LOAD cycle. The pulse count of each short run is compared with ceil(n/4).

// File: rtl/vid_load_pkg.sv
package vid_load_pkg;

  // Next phase of a wrapping period counter.
  function automatic int unsigned phase_next(input int unsigned ph, input int unsigned period);
    return (ph + 1 >= period) ? 0 : ph + 1;
  endfunction

  // Address after one word has been consumed.
  function automatic logic [63:0] addr_after(input logic [63:0] cur, input int unsigned step);
    return cur + 64'(step);
  endfunction

  // Words produced by an enable run of n cycles at the given period.
  function automatic int unsigned words_in_run(input int unsigned n, input int unsigned period);
    return (n + period - 1) / period;
  endfunction

endpackage

// File: rtl/de_delay_line.sv
module de_delay_line #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_i,
  output logic [DEPTH-1:0] taps_o
);
  logic [DEPTH-1:0] stage_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign taps_o = stage_q;

  // R4: each tap carries the previous tap one cycle later
  generate
    if (DEPTH > 1) begin : g_chk
      tap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (taps_o[1] == $past(taps_o[0])));
    end
  endgenerate
endmodule

// File: rtl/load_pacer.sv
module load_pacer
  import vid_load_pkg::*;
#(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic load_o,
  output logic first_o
);
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph_q;
  logic            run_q;
  logic            load_q;
  logic            first_q;
  logic            slot_open;
  logic            run_start;

  assign slot_open = run_i && (ph_q == '0);
  assign run_start = run_i && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= '0;
      run_q   <= 1'b0;
      load_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      run_q   <= run_i;
      load_q  <= slot_open;
      first_q <= run_start;
      if (run_i) ph_q <= PH_W'(phase_next(int'(ph_q), PERIOD));
      else       ph_q <= '0;
    end
  end

  assign load_o  = load_q;
  assign first_o = first_q;

  // R2
  first_is_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> load_o);

  // R3
  generate
    if (PERIOD > 1) begin : g_pulse_chk
      load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
    end
  endgenerate
endmodule

// File: rtl/vaddr_counter.sv
module vaddr_counter
  import vid_load_pkg::*;
#(
  parameter int AW   = 24,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_i,
  input  logic [AW-1:0] base_i,
  input  logic          advance_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_next;

  always_comb begin
    addr_next = addr_q;
    if (reload_i)       addr_next = base_i;
    else if (advance_i) addr_next = AW'(addr_after(64'(addr_q), STEP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_next;
  end

  assign addr_o = addr_q;

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(advance_i) && !$past(reload_i)
      |-> addr_o == $past(addr_o) + AW'(STEP));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(advance_i) && !$past(reload_i) |-> $stable(addr_o));

  // R6
  addr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reload_i) |-> addr_o == $past(base_i));
endmodule

// File: rtl/pix_delay.sv
module pix_delay #(
  parameter int LAT = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic pulse_o
);
  logic [LAT-1:0] sr_q;

  generate
    for (genvar i = 0; i < LAT; i++) begin : g_tap
      if (i == 0) begin : g_in
        always_ff @(posedge clk) begin
          if (!rst_n) sr_q[0] <= 1'b0;
          else        sr_q[0] <= pulse_i;
        end
      end else begin : g_mid
        always_ff @(posedge clk) begin
          if (!rst_n) sr_q[i] <= 1'b0;
          else        sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  assign pulse_o = sr_q[LAT-1];

  // R7
  pix_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dl_word_loader.sv
module dl_word_loader #(
  parameter int ADDR_W      = 24,
  parameter int LOAD_LAT    = 4,
  parameter int DETECT_LAT  = 2,
  parameter int LOAD_PERIOD = 4,
  parameter int WORD_BYTES  = 2,
  parameter int PIX_LAT     = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_i,
  input  logic              frame_start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] vaddr_o,
  output logic              first_pix_o
);
  localparam int PIPE_DEPTH = LOAD_LAT - 1;

  logic [PIPE_DEPTH-1:0] de_taps;
  logic                  de_seen;
  logic                  pace_run;
  logic                  load_word;
  logic                  first_word;

  de_delay_line #(.DEPTH(PIPE_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (de_i),
    .taps_o (de_taps)
  );

  assign de_seen  = de_taps[DETECT_LAT-1];
  assign pace_run = de_taps[PIPE_DEPTH-1];

  load_pacer #(.PERIOD(LOAD_PERIOD)) u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (pace_run),
    .load_o  (load_word),
    .first_o (first_word)
  );

  vaddr_counter #(.AW(ADDR_W), .STEP(WORD_BYTES)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_i  (frame_start_i),
    .base_i    (base_i),
    .advance_i (load_word),
    .addr_o    (vaddr_o)
  );

  pix_delay #(.LAT(PIX_LAT)) u_pix (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (first_word),
    .pulse_o (first_pix_o)
  );

  assign load_o = load_word;

  generate
    if (LOAD_LAT == 4 && DETECT_LAT == 2 && LOAD_PERIOD == 4) begin : g_top_chk
      // R2
      detect_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_seen |-> $past(de_i, 2));

      // R2
      first_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_word |-> load_word && $past(de_i, 4));

      // R4
      load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(de_i, 4));

      // R3
      load_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_o, 4) && $past(de_i, 4) && $past(de_i, 5) && $past(de_i, 6)
          && $past(de_i, 7) |-> load_o);
    end
  endgenerate
endmodule

// File: tb/dl_word_loader_test.sv
module dl_word_loader_test;
  localparam int AW = 24;
  localparam int N  = 4000;
  localparam int M  = N + 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          de_i;
  logic          frame_start_i;
  logic [AW-1:0] base_i;
  logic          load_o;
  logic [AW-1:0] vaddr_o;
  logic          first_pix_o;

  always #4 clk = ~clk;

  dl_word_loader uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .de_i          (de_i),
    .frame_start_i (frame_start_i),
    .base_i        (base_i),
    .load_o        (load_o),
    .vaddr_o       (vaddr_o),
    .first_pix_o   (first_pix_o)
  );

  bit          de_seq    [M];
  bit          fs_seq    [M];
  logic [AW-1:0] base_seq[M];
  bit          exp_load  [M];
  bit          exp_lead  [M];
  bit          exp_first [M];
  logic [AW-1:0] exp_addr[M];
  bit          act_load  [M];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] cur, input bit ld,
                                               input bit fs, input logic [AW-1:0] base);
    if (fs) return base;
    if (ld) return cur + AW'(2);
    return cur;
  endfunction

  function automatic int ceil4(input int n);
    return (n + 3) / 4;
  endfunction

  task automatic check(input string tag, input int cyc, input logic [AW-1:0] got,
                       input logic [AW-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, got, want);
    end
  endtask

  task automatic place_run(input int s, input int n);
    for (int i = s; i < s + n; i++) de_seq[i] = 1'b1;
  endtask

  task automatic count_window(input string tag, input int lo, input int hi, input int n);
    int cnt = 0;
    for (int c = lo; c <= hi; c++) if (act_load[c]) cnt++;
    check(tag, lo, AW'(cnt), AW'(ceil4(n)));
  endtask

  task automatic build_stimulus();
    int c;
    void'($urandom(32'h5EED));
    for (int i = 0; i < M; i++) begin
      de_seq[i] = 0; fs_seq[i] = 0; base_seq[i] = '0;
      exp_load[i] = 0; exp_lead[i] = 0; exp_first[i] = 0; act_load[i] = 0;
    end
    // Directed corner cases
    place_run(10, 1);
    fs_seq[20] = 1; base_seq[20] = 24'h001000;
    place_run(30, 5);
    place_run(60, 40);
    fs_seq[64] = 1; base_seq[64] = 24'h0ABC00;   // reload on a LOAD cycle
    place_run(120, 4);
    place_run(130, 8);
    fs_seq[160] = 1; base_seq[160] = 24'hFFFFFC; // wrap through the top
    place_run(170, 12);
    // Random section
    c = 200;
    while (c < N - 100) begin
      int hi_len = $urandom_range(70, 1);
      int lo_len = $urandom_range(25, 1);
      place_run(c, hi_len);
      c += hi_len + lo_len;
    end
    for (int i = 200; i < N; i++) begin
      if ($urandom_range(63, 0) == 0) begin
        fs_seq[i]   = 1;
        base_seq[i] = AW'($urandom) & ~AW'(1);
      end
    end
  endtask

  task automatic build_expected();
    bit prev = 0;
    int start = 0;
    for (int c = 0; c < N; c++) begin
      if (de_seq[c] && !prev) start = c;
      if (de_seq[c] && ((c - start) % 4 == 0)) begin
        exp_load[c + 4] = 1;
        if (c == start) begin
          exp_lead[c + 4]   = 1;
          exp_first[c + 22] = 1;
        end
      end
      prev = de_seq[c];
    end
    exp_addr[0] = '0;
    for (int c = 0; c < M - 1; c++)
      exp_addr[c + 1] = model_addr(exp_addr[c], exp_load[c], fs_seq[c], base_seq[c]);
  endtask

  initial begin
    rst_n = 0; de_i = 0; frame_start_i = 0; base_i = '0;
    build_stimulus();
    build_expected();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 load", -1, AW'(load_o), '0);
    check("R1 first", -1, AW'(first_pix_o), '0);
    check("R1 vaddr", -1, vaddr_o, '0);
    de_i = 1; frame_start_i = 1; base_i = 24'h123456; // ignored while in reset
    @(negedge clk);
    de_i = 0; frame_start_i = 0; base_i = '0;
    rst_n = 1;
    for (int c = 0; c < N + 40; c++) begin
      @(negedge clk);
      act_load[c] = load_o;
      if (c == 0) begin
        check("R1 load after release", c, AW'(load_o), '0);
        check("R1 vaddr after release", c, vaddr_o, '0);
      end
      if (load_o !== exp_load[c]) begin
        if (exp_load[c] && exp_lead[c]) check("R2 first load", c, AW'(load_o), AW'(exp_load[c]));
        else if (exp_load[c])           check("R3 repeat load", c, AW'(load_o), AW'(exp_load[c]));
        else                            check("R4 stray load", c, AW'(load_o), AW'(exp_load[c]));
      end else checks++;
      check("R7 first pixel", c, AW'(first_pix_o), AW'(exp_first[c]));
      if (c > 0 && fs_seq[c - 1]) check("R6 reload", c, vaddr_o, exp_addr[c]);
      else                        check("R5 address", c, vaddr_o, exp_addr[c]);
      de_i          = (c < N) ? de_seq[c] : 1'b0;
      frame_start_i = (c < N) ? fs_seq[c] : 1'b0;
      base_i        = (c < N) ? base_seq[c] : '0;
    end
    // R8: pulse counts of short directed runs
    count_window("R8 run of 1", 11, 29, 1);
    count_window("R8 run of 5", 31, 55, 5);
    count_window("R8 run of 4", 121, 129, 4);
    count_window("R8 run of 8", 131, 150, 8);
    count_window("R8 run of 12", 171, 195, 12);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule